// File: doc/BRIEF.md
# Parallel Complex Multiply-Accumulate Tree

This block multiplies several pairs of signed complex numbers in the same clock cycle and adds all the lane products into one complex total. Each lane brings an operand `a` and an operand `b`. The real and imaginary parts of every lane travel on four flat buses, with the lanes packed side by side. A register stage forms every lane product. A registered binary adder tree then folds the products, one level per cycle, down to a single real sum and a single imaginary sum.

A build-time switch makes the block use the complex conjugate of `b`. This is the usual choice for correlation and beamforming weights. The result is never rounded or clipped: the output is wide enough to hold the exact sum of every lane at any operand values. A synchronous reset clears the pipeline. A clock enable freezes the whole pipeline, so a consumer that stalls loses no data.

Top module: `cplx_mac_tree`

## Requirements
- R1: With `CONJ_B` = 0, each lane contributes a real part of ar*br − ai*bi and an imaginary part of ar*bi + ai*br. The outputs are the exact sums of these lane contributions.
- R2: With `CONJ_B` = 1, each lane contributes a real part of ar*br + ai*bi and an imaginary part of ai*br − ar*bi.
- R3: Each output is 2*OPW+1+ceil_log2(LANES) bits wide, in two's complement. The result is exact for every mix of the values 2^(OPW−1)−1, −2^(OPW−1) and −(2^(OPW−1)−1) across the four operands.
- R4: An operand set that is sampled on an enabled clock edge appears at the outputs after exactly 1+ceil_log2(LANES) enabled edges, counting that edge.
- R5: Lane i is carried on bits (i+1)*OPW−1 down to i*OPW of each of the four input buses.
- R6: While `ce` is low, no pipeline register changes. Operands presented in that time are not taken in, and the outputs stay constant.
- R7: While `rst` is high at a clock edge, both outputs become zero and all data in flight is discarded.
- R8: When LANES is not a power of two, the unused adder inputs count as zero. The latency still follows R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for the whole pipeline |
| a_re_bus | input | LANES*OPW | Real parts of operand a, lane i at bits (i+1)*OPW−1 : i*OPW |
| a_im_bus | input | LANES*OPW | Imaginary parts of operand a |
| b_re_bus | input | LANES*OPW | Real parts of operand b |
| b_im_bus | input | LANES*OPW | Imaginary parts of operand b |
| sum_re | output | 2*OPW+1+ceil_log2(LANES) | Real part of the summed products |
| sum_im | output | 2*OPW+1+ceil_log2(LANES) | Imaginary part of the summed products |

## Verification
The zero-flush assertion assumes that an operand set of all zeros on every bus yields a zero product in every lane. It then requires the outputs to be zero once that many enabled zero cycles have filled the pipeline. The bench therefore inserts runs of all-zero operands, some of them broken up by disabled cycles carrying non-zero data, and the counter must treat those disabled cycles correctly. The conjugate self-product assertion assumes that when b equals a in a lane, the lane's imaginary part cancels. The random stimulus sets b equal to a on some cycles so that this property is actually triggered. The hold assertions take `ce` as a clean level sampled at each edge, and the bench changes it only at falling edges.

// File: rtl/cmat_pkg.sv
package cmat_pkg;

  // Number of adder levels needed to fold n terms into one (0 for n <= 1).
  function automatic int tree_depth(input int n);
    int d;
    int span;
    d = 0;
    span = 1;
    while (span < n) begin
      span = span * 2;
      d = d + 1;
    end
    return d;
  endfunction

  // Width of one lane product: doubled for the multiply, one more for the add.
  function automatic int lane_prod_width(input int opw);
    return 2 * opw + 1;
  endfunction

  // Full-precision width of the tree output.
  function automatic int total_width(input int opw, input int lanes);
    return lane_prod_width(opw) + tree_depth(lanes);
  endfunction

endpackage

// File: rtl/cmat_lane_mult.sv
module cmat_lane_mult
  import cmat_pkg::*;
#(
  parameter int OPW    = 16,
  parameter bit CONJ_B = 1'b0,
  localparam int PW    = lane_prod_width(OPW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic [OPW-1:0] ar,
  input  logic [OPW-1:0] ai,
  input  logic [OPW-1:0] br,
  input  logic [OPW-1:0] bi,
  output logic [PW-1:0]  prod_re,
  output logic [PW-1:0]  prod_im
);

  // Sign-extend an operand to the product width before any arithmetic.
  function automatic logic signed [PW-1:0] widen(input logic [OPW-1:0] v);
    return PW'($signed(v));
  endfunction

  // Exact signed product; the true value fits in 2*OPW bits.
  function automatic logic signed [PW-1:0] mul_w(input logic [OPW-1:0] x,
                                                 input logic [OPW-1:0] y);
    return widen(x) * widen(y);
  endfunction

  logic signed [PW-1:0] p_rr;
  logic signed [PW-1:0] p_ii;
  logic signed [PW-1:0] p_ri;
  logic signed [PW-1:0] p_ir;
  logic signed [PW-1:0] re_nxt;
  logic signed [PW-1:0] im_nxt;

  always_comb begin
    p_rr = mul_w(ar, br);
    p_ii = mul_w(ai, bi);
    p_ri = mul_w(ar, bi);
    p_ir = mul_w(ai, br);
  end

  generate
    if (CONJ_B) begin : g_conj
      assign re_nxt = p_rr + p_ii;
      assign im_nxt = p_ir - p_ri;
    end else begin : g_plain
      assign re_nxt = p_rr - p_ii;
      assign im_nxt = p_ri + p_ir;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_re <= '0;
      prod_im <= '0;
    end else if (ce) begin
      prod_re <= re_nxt;
      prod_im <= im_nxt;
    end
  end

  // R6: the product register does not move on a disabled edge.
  a_r6_lane_hold : assert property (@(posedge clk) disable iff (rst)
    (!$past(ce) && !$past(rst)) |-> ($stable(prod_re) && $stable(prod_im)));

  // R1/R2: a zero b operand always yields a zero lane product.
  a_r1_zero_b : assert property (@(posedge clk) disable iff (rst)
    $past(ce && (br == '0) && (bi == '0)) |-> ((prod_re == '0) && (prod_im == '0)));

  generate
    if (CONJ_B) begin : g_conj_chk
      // R2: a times conj(a) has no imaginary part.
      a_r2_conj_self : assert property (@(posedge clk) disable iff (rst)
        $past(ce && (ar == br) && (ai == bi)) |-> (prod_im == '0));
    end
  endgenerate

endmodule

// File: rtl/cmat_add_level.sv
module cmat_add_level #(
  parameter int IN_CNT = 2,
  parameter int W      = 8,
  localparam int OUT_CNT = IN_CNT / 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ce,
  input  logic [IN_CNT-1:0][W-1:0]    in_vec,
  output logic [OUT_CNT-1:0][W-1:0]   out_vec
);

  // Both terms are already sign-extended to the full output width.
  function automatic logic [W-1:0] add_pair(input logic [W-1:0] x,
                                            input logic [W-1:0] y);
    return W'($signed(x) + $signed(y));
  endfunction

  logic [OUT_CNT-1:0][W-1:0] sum_nxt;

  generate
    for (genvar j = 0; j < OUT_CNT; j++) begin : g_pair
      assign sum_nxt[j] = add_pair(in_vec[2*j], in_vec[2*j+1]);

      always_ff @(posedge clk) begin
        if (rst) begin
          out_vec[j] <= '0;
        end else if (ce) begin
          out_vec[j] <= sum_nxt[j];
        end
      end
    end
  endgenerate

  // R6: a tree level holds its partial sums while disabled.
  a_r6_level_hold : assert property (@(posedge clk) disable iff (rst)
    (!$past(ce) && !$past(rst)) |-> $stable(out_vec));

endmodule

// File: rtl/cmat_adder_tree.sv
module cmat_adder_tree
  import cmat_pkg::*;
#(
  parameter int N     = 8,
  parameter int IN_W  = 33,
  parameter int OUT_W = 36,
  localparam int DEPTH = tree_depth(N),
  localparam int PAD   = 1 << DEPTH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce,
  input  logic [N-1:0][IN_W-1:0] terms,
  output logic [OUT_W-1:0]       total
);

  function automatic logic [OUT_W-1:0] sext(input logic [IN_W-1:0] v);
    return OUT_W'($signed(v));
  endfunction

  logic [PAD-1:0][OUT_W-1:0] node [DEPTH+1];
  logic [PAD-1:0][OUT_W-1:0] lvl0;

  // Level 0: sign-extended products, with zero terms filling the unused slots.
  generate
    for (genvar i = 0; i < PAD; i++) begin : g_leaf
      if (i < N) begin : g_used
        assign lvl0[i] = sext(terms[i]);
      end else begin : g_pad
        assign lvl0[i] = '0;
      end
    end
  endgenerate

  assign node[0] = lvl0;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
      localparam int CNT  = PAD >> k;
      localparam int HALF = CNT / 2;
      logic [HALF-1:0][OUT_W-1:0] lvl_out;

      cmat_add_level #(
        .IN_CNT (CNT),
        .W      (OUT_W)
      ) u_level (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .in_vec  (node[k][CNT-1:0]),
        .out_vec (lvl_out)
      );

      assign node[k+1] = {{((PAD-HALF)*OUT_W){1'b0}}, lvl_out};
    end
  endgenerate

  assign total = node[DEPTH][0];

endmodule

// File: rtl/cplx_mac_tree.sv
module cplx_mac_tree
  import cmat_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int OPW    = 16,
  parameter bit CONJ_B = 1'b0,
  localparam int PW    = lane_prod_width(OPW),
  localparam int SUM_W = total_width(OPW, LANES),
  localparam int LAT   = 1 + tree_depth(LANES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic [LANES*OPW-1:0] a_re_bus,
  input  logic [LANES*OPW-1:0] a_im_bus,
  input  logic [LANES*OPW-1:0] b_re_bus,
  input  logic [LANES*OPW-1:0] b_im_bus,
  output logic [SUM_W-1:0]     sum_re,
  output logic [SUM_W-1:0]     sum_im
);

  logic [LANES-1:0][PW-1:0] lane_re;
  logic [LANES-1:0][PW-1:0] lane_im;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      cmat_lane_mult #(
        .OPW    (OPW),
        .CONJ_B (CONJ_B)
      ) u_mult (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .ar      (a_re_bus[i*OPW +: OPW]),
        .ai      (a_im_bus[i*OPW +: OPW]),
        .br      (b_re_bus[i*OPW +: OPW]),
        .bi      (b_im_bus[i*OPW +: OPW]),
        .prod_re (lane_re[i]),
        .prod_im (lane_im[i])
      );
    end
  endgenerate

  cmat_adder_tree #(
    .N     (LANES),
    .IN_W  (PW),
    .OUT_W (SUM_W)
  ) u_tree_re (
    .clk   (clk),
    .rst   (rst),
    .ce    (ce),
    .terms (lane_re),
    .total (sum_re)
  );

  cmat_adder_tree #(
    .N     (LANES),
    .IN_W  (PW),
    .OUT_W (SUM_W)
  ) u_tree_im (
    .clk   (clk),
    .rst   (rst),
    .ce    (ce),
    .terms (lane_im),
    .total (sum_im)
  );

  // Checker state: enabled cycles of all-zero operands since the last non-zero set.
  logic       ops_zero;
  logic [7:0] zero_run;

  assign ops_zero = (a_re_bus == '0) && (a_im_bus == '0) &&
                    (b_re_bus == '0) && (b_im_bus == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_run <= 8'(LAT);
    end else if (ce) begin
      if (!ops_zero) begin
        zero_run <= '0;
      end else if (zero_run < 8'(LAT)) begin
        zero_run <= zero_run + 8'd1;
      end
    end
  end

  // R4: once LAT enabled zero cycles have passed, nothing non-zero is left in flight.
  a_r4_zero_flush : assert property (@(posedge clk) disable iff (rst)
    (zero_run >= 8'(LAT)) |-> ((sum_re == '0) && (sum_im == '0)));

endmodule

// File: tb/test_cplx_mac_tree.sv
module test_cplx_mac_tree;

  localparam int W   = 16;
  localparam int NA  = 8;
  localparam int NB  = 5;

  function automatic int clog2i(input int n);
    int d;
    d = 0;
    while ((1 << d) < n) d++;
    return d;
  endfunction

  localparam int LAT_A = 1 + clog2i(NA);
  localparam int LAT_B = 1 + clog2i(NB);
  localparam int SW_A  = 2*W + 1 + clog2i(NA);
  localparam int SW_B  = 2*W + 1 + clog2i(NB);

  typedef struct {
    longint re;
    longint im;
    longint due;
    string  tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce  = 1'b0;
  logic [NA*W-1:0] ar = '0, ai = '0, br = '0, bi = '0;
  logic [SW_A-1:0] sre_a, sim_a;
  logic [SW_B-1:0] sre_b, sim_b;

  int     n_tests = 0;
  int     n_fail  = 0;
  longint en_cnt  = 0;
  bit     hold_edge = 1'b0;
  item_t  q_a[$];
  item_t  q_b[$];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  cplx_mac_tree #(.LANES(NA), .OPW(W), .CONJ_B(1'b0)) i_cplx_mac_tree (
    .clk(clk), .rst(rst), .ce(ce),
    .a_re_bus(ar), .a_im_bus(ai), .b_re_bus(br), .b_im_bus(bi),
    .sum_re(sre_a), .sum_im(sim_a)
  );

  cplx_mac_tree #(.LANES(NB), .OPW(W), .CONJ_B(1'b1)) i_cplx_mac_tree_conj (
    .clk(clk), .rst(rst), .ce(ce),
    .a_re_bus(ar[NB*W-1:0]), .a_im_bus(ai[NB*W-1:0]),
    .b_re_bus(br[NB*W-1:0]), .b_im_bus(bi[NB*W-1:0]),
    .sum_re(sre_b), .sum_im(sim_b)
  );

  always @(posedge clk) begin
    hold_edge <= !ce && !rst;
    if (ce && !rst) en_cnt <= en_cnt + 1;
  end

  task automatic check(input string req, input longint got, input longint exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint lane(input logic [NA*W-1:0] bus, input int i);
    logic signed [W-1:0] v;
    v = bus[i*W +: W];
    return longint'(v);
  endfunction

  // Reference: exact complex sum over n lanes, restated from R1/R2.
  task automatic ref_sum(input bit conj, input int n, output longint re, output longint im);
    re = 0;
    im = 0;
    for (int i = 0; i < n; i++) begin
      longint xr, xi, yr, yi;
      xr = lane(ar, i); xi = lane(ai, i); yr = lane(br, i); yi = lane(bi, i);
      if (conj) begin
        re += xr*yr + xi*yi;
        im += xi*yr - xr*yi;
      end else begin
        re += xr*yr - xi*yi;
        im += xr*yi + xi*yr;
      end
    end
  endtask

  function automatic logic [NA*W-1:0] splat(input int v);
    logic [NA*W-1:0] r;
    for (int i = 0; i < NA; i++) r[i*W +: W] = W'(v);
    return r;
  endfunction

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // Driver: present operands after a falling edge and queue expected sums.
  task automatic drive(input logic [NA*W-1:0] xar, input logic [NA*W-1:0] xai,
                       input logic [NA*W-1:0] xbr, input logic [NA*W-1:0] xbi,
                       input bit en, input string tag);
    item_t it;
    @(negedge clk);
    ar = xar; ai = xai; br = xbr; bi = xbi; ce = en;
    if (en) begin
      ref_sum(1'b0, NA, it.re, it.im);
      it.due = en_cnt + LAT_A; it.tag = tag;
      q_a.push_back(it);
      ref_sum(1'b1, NB, it.re, it.im);
      it.due = en_cnt + LAT_B; it.tag = {"R2/R8 ", tag};
      q_b.push_back(it);
    end
  endtask

  // Monitor: compare results when they fall due; check holds on disabled edges.
  longint last_ra = 0, last_ia = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && hold_edge) begin
        check("R6 hold re", longint'($signed(sre_a)), last_ra);
        check("R6 hold im", longint'($signed(sim_a)), last_ia);
      end
      while (q_a.size() > 0 && q_a[0].due == en_cnt) begin
        item_t it;
        it = q_a.pop_front();
        check({it.tag, " re"}, longint'($signed(sre_a)), it.re);
        check({it.tag, " im"}, longint'($signed(sim_a)), it.im);
      end
      while (q_b.size() > 0 && q_b[0].due == en_cnt) begin
        item_t it;
        it = q_b.pop_front();
        check({it.tag, " re"}, longint'($signed(sre_b)), it.re);
        check({it.tag, " im"}, longint'($signed(sim_b)), it.im);
      end
      last_ra = longint'($signed(sre_a));
      last_ia = longint'($signed(sim_a));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ce = 1'b1;
    ar = splat(77); ai = splat(-5); br = splat(3); bi = splat(9);
    q_a.delete(); q_b.delete();
    repeat (3) @(negedge clk);
    check("R7 reset re", longint'($signed(sre_a)), 0);
    check("R7 reset im", longint'($signed(sim_a)), 0);
    check("R7 reset conj re", longint'($signed(sre_b)), 0);
    rst = 1'b0; ce = 1'b0;
    ar = '0; ai = '0; br = '0; bi = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int edge_v[3];
    edge_v[0] = (1 << (W-1)) - 1;
    edge_v[1] = -(1 << (W-1));
    edge_v[2] = -((1 << (W-1)) - 1);

    do_reset();

    repeat (LAT_A + 1) drive('0, '0, '0, '0, 1'b1, "R1 zeros");
    drive(splat(2), splat(3), splat(4), splat(5), 1'b1, "R1 small");
    drive(splat(8), splat(6), splat(7), splat(4), 1'b1, "R1 small2");

    // R3: every mix of edge values on the four operands.
    for (int p = 0; p < 3; p++)
      for (int q = 0; q < 3; q++)
        for (int r = 0; r < 3; r++)
          for (int s = 0; s < 3; s++)
            drive(splat(edge_v[p]), splat(edge_v[q]), splat(edge_v[r]),
                  splat(edge_v[s]), 1'b1, "R3 edge");

    // R5: one lane active at a time.
    for (int i = 0; i < NA; i++) begin
      logic [NA*W-1:0] x, y;
      x = '0; y = '0;
      x[i*W +: W] = W'(i + 1);
      y[i*W +: W] = W'(-(3*i + 2));
      drive(x, y, y, x, 1'b1, "R5 lane");
    end

    // R4: impulse between zero runs.
    repeat (LAT_A) drive('0, '0, '0, '0, 1'b1, "R4 pre");
    drive(splat(100), splat(-7), splat(11), splat(3), 1'b1, "R4 impulse");
    repeat (LAT_A + 1) drive('0, '0, '0, '0, 1'b1, "R4 post");

    // R1/R2/R6: distinct random lanes, some with b equal to a, with gaps in ce.
    for (int c = 0; c < 300; c++) begin
      logic [NA*W-1:0] v[4];
      bit en;
      for (int k = 0; k < 4; k++)
        for (int i = 0; i < NA; i++) begin
          seed = lcg(seed);
          v[k][i*W +: W] = seed[31:16];
        end
      if (c % 7 == 3) begin v[2] = v[0]; v[3] = v[1]; end
      seed = lcg(seed);
      en = (seed[27:25] != 3'd0);
      drive(v[0], v[1], v[2], v[3], en, en ? "R1 random" : "R6 gap");
      if (c % 50 == 10) repeat (LAT_A + 1) drive('0, '0, '0, '0, 1'b1, "R4 flush");
    end

    // R7: reset with data in flight.
    drive(splat(1234), splat(-999), splat(321), splat(45), 1'b1, "R7 pre");
    do_reset();
    repeat (LAT_A + 2) drive('0, '0, '0, '0, 1'b1, "R7 after");

    repeat (LAT_A + 2) @(negedge clk);
    check("R4 queue drained", longint'(q_a.size() + q_b.size()), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule